// File: doc/BRIEF.md
# Cascadable Presettable Binary Up/Down Counter

This block is a synchronous binary counter built from identical 4-bit stages that share one clock. Each stage moves its count one step per rising clock edge, upward or downward as a direction input selects, but only while its active-low carry-in is low. Each stage decodes an active-low carry-out from its own count, the direction and its carry-in. That carry-out drives the carry-in of the stage above it, so the chain counts as one wide binary number. The carry-out of the top stage also serves as a terminal-count flag.

Two overriding controls act at once, with no clock edge needed. An active-high clear forces the count to zero. An active-high load makes the count show the preset value. While either control is high, the clock cannot advance the count. Clear takes priority over load. A separate synchronous active-low reset initialises the storage on a clock edge. Typical uses include up/down difference counting and programmable division: load a ratio, count down, and let the terminal carry-out mark the period.

Top module: `udc_chain`

## Requirements
- R1: When `up_dn`=1, `cin_n`=0, `clr`=0 and `load`=0, each rising clock edge raises `count` by one.
- R2: When `up_dn`=0, `cin_n`=0, `clr`=0 and `load`=0, each rising clock edge lowers `count` by one.
- R3: While `cin_n`=1, with `clr` and `load` low, clock edges leave `count` unchanged.
- R4: `clr`=1 makes `count` zero within the same cycle, without waiting for a clock edge. The count stays zero on every edge while `clr` is held.
- R5: `load`=1 makes `count` equal `preset` within the same cycle. Edges while `load` is held do not count, and counting resumes from the loaded value after `load` falls.
- R6: With `clr` and `load` both high, `count` is zero.
- R7: Counting up from all ones wraps to all zeros. Counting down from all zeros wraps to all ones.
- R8: With `up_dn`=1, a stage's carry-out is 0 exactly when its count is all ones and its carry-in is 0. The top-level `cout_n` follows this rule for the full count.
- R9: With `up_dn`=0, a stage's carry-out is 0 exactly when its count is zero and its carry-in is 0. The carry-out responds combinationally within the cycle.
- R10: Stage k (k>0) changes its 4-bit field (bits 4k+3..4k) only on an edge where stage k-1's carry-out was 0, so the chain counts as one binary number.
- R11: `rst_n`=0 on a rising edge clears `count` to zero. This reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low storage reset |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n | input | 1 | Active-low count enable for the lowest stage |
| load | input | 1 | Active-high immediate load of `preset` |
| clr | input | 1 | Active-high immediate clear, overrides `load` |
| preset | input | STAGE_W*NUM_STAGES | Value shown and stored while `load` is high |
| count | output | STAGE_W*NUM_STAGES | Current count, bit 0 is the LSB |
| cout_n | output | 1 | Active-low carry-out of the top stage |

## Verification
The assertions check on every cycle the step relations: increment, decrement and hold across an edge, and the value left after a clear or a load is released. They also check that a carry-out can only be low with its carry-in low and at the right terminal value, and that an upper stage moves only after a low carry from below. The bench scenarios show what the assertions cannot. These are the same-cycle response of `count` and `cout_n` to `clr`, `load` and `cin_n` between edges, the priority of clear over load, both wrap points across the stage boundary, and the synchronous reset.

// File: rtl/udc_pkg.sv
// Shared types for the up/down counter chain.
// Assumes: nothing beyond IEEE 1800-2017.
package udc_pkg;
    // Direction encoding on the up_dn pin.
    typedef enum logic {
        CNT_DOWN = 1'b0,
        CNT_UP   = 1'b1
    } cnt_dir_e;

    // Default width of one stage.
    localparam int unsigned STAGE_W_DEF = 4;
endpackage

// File: rtl/udc_next.sv
// Next stored value of one stage.
// Clear beats load, load beats counting, and counting needs an active-low enable.
// Assumes: cur already reflects any clear or load bypass.
module udc_next
    import udc_pkg::*;
#(
    parameter int unsigned W = STAGE_W_DEF
) (
    input  logic [W-1:0] cur,
    input  logic         up_dn,
    input  logic         cin_n,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] preset,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Select the value to store on the next edge.
    always_comb begin
        if (clr) begin
            nxt = '0;
        end else if (load) begin
            nxt = preset;
        end else if (!cin_n) begin
            nxt = (cnt_dir_e'(up_dn) == CNT_UP) ? cur + ONE : cur - ONE;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/udc_carry.sv
// Active-low carry-out of one stage, decoded from the visible count.
// Assumes: called with the bypassed count, so a load or clear shows at once.
module udc_carry
    import udc_pkg::*;
#(
    parameter int unsigned W = STAGE_W_DEF
) (
    input  logic [W-1:0] cur,
    input  logic         up_dn,
    input  logic         cin_n,
    output logic         cout_n
);
    logic at_top;
    logic at_bottom;

    // Detect the two terminal values.
    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
    end

    // Choose the terminal for the current direction, gated by carry-in.
    always_comb begin
        if (cin_n) begin
            cout_n = 1'b1;
        end else if (cnt_dir_e'(up_dn) == CNT_UP) begin
            cout_n = ~at_top;
        end else begin
            cout_n = ~at_bottom;
        end
    end
endmodule

// File: rtl/udc_stage.sv
// One counter stage: a register, the clear/load bypass onto the output,
// next-state logic and the carry decoder.
// Assumes: clr, load and preset come from synchronous logic in the clk domain.
// The bypass makes them visible within the cycle, and the register takes
// them on the next edge.
module udc_stage
    import udc_pkg::*;
#(
    parameter int unsigned W = STAGE_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_dn,
    input  logic         cin_n,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         cout_n
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    // Visible count: clear first, then load, else the stored value.
    always_comb begin
        if (clr) begin
            count = '0;
        end else if (load) begin
            count = preset;
        end else begin
            count = state_q;
        end
    end

    udc_next #(.W(W)) u_next (
        .cur    (count),
        .up_dn  (up_dn),
        .cin_n  (cin_n),
        .load   (load),
        .clr    (clr),
        .preset (preset),
        .nxt    (state_d)
    );

    udc_carry #(.W(W)) u_carry (
        .cur    (count),
        .up_dn  (up_dn),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    // Storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !clr && !load && !cin_n && up_dn) && !clr && !load)
        |-> count == $past(count) + ONE); // R1

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !clr && !load && !cin_n && !up_dn) && !clr && !load)
        |-> count == $past(count) - ONE); // R2

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !clr && !load && cin_n) && !clr && !load)
        |-> $stable(count)); // R3

    AST_CLEAR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && clr) && !clr && !load)
        |-> count == '0); // R4

    AST_LOAD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && load && !clr) && !clr && !load)
        |-> count == $past(preset)); // R5

    AST_COUT_UP_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (!cout_n && up_dn) |-> (!cin_n && (&count))); // R8

    AST_COUT_DOWN_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (!cout_n && !up_dn) |-> (!cin_n && !(|count))); // R9
endmodule

// File: rtl/udc_chain.sv
// Top: NUM_STAGES identical stages on one clock. Each carry-out feeds
// the carry-in of the stage above. The carry path is combinational, so
// it settles across the whole chain within one clock period.
// Assumes: NUM_STAGES >= 1.
module udc_chain
    import udc_pkg::*;
#(
    parameter int unsigned STAGE_W    = STAGE_W_DEF,
    parameter int unsigned NUM_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          up_dn,
    input  logic                          cin_n,
    input  logic                          load,
    input  logic                          clr,
    input  logic [STAGE_W*NUM_STAGES-1:0] preset,
    output logic [STAGE_W*NUM_STAGES-1:0] count,
    output logic                          cout_n
);
    localparam int unsigned TOTAL_W = STAGE_W * NUM_STAGES;

    logic [NUM_STAGES:0] carry_n;

    // Feed the external enable into the bottom of the carry ripple.
    always_comb carry_n[0] = cin_n;

    // Build the stages and link each carry-out to the next carry-in.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        udc_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_dn  (up_dn),
            .cin_n  (carry_n[i]),
            .load   (load),
            .clr    (clr),
            .preset (preset[i*STAGE_W +: STAGE_W]),
            .count  (count[i*STAGE_W +: STAGE_W]),
            .cout_n (carry_n[i+1])
        );

        if (i > 0) begin : g_link_chk
            AST_UPPER_WAITS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n && !clr && !load && carry_n[i]) && !clr && !load)
                |-> $stable(count[i*STAGE_W +: STAGE_W])); // R10
        end
    end

    // The top stage's carry-out is the chain's terminal flag.
    always_comb cout_n = carry_n[NUM_STAGES];

    AST_TOP_COUT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cout_n && up_dn) |-> (count == {TOTAL_W{1'b1}})); // R8
endmodule

// File: tb/sim_udc_chain.sv
module sim_udc_chain;
    localparam int unsigned SW = 4;
    localparam int unsigned NS = 2;
    localparam int unsigned TW = SW * NS;
    localparam int unsigned NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_dn = 1'b1;
    logic          cin_n = 1'b1;
    logic          load = 1'b0;
    logic          clr = 1'b0;
    logic [TW-1:0] preset = '0;
    logic [TW-1:0] count;
    logic          cout_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    udc_chain #(.STAGE_W(SW), .NUM_STAGES(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .up_dn(up_dn), .cin_n(cin_n),
        .load(load), .clr(clr), .preset(preset),
        .count(count), .cout_n(cout_n)
    );

    // Row: {load, clr, cin_n, up_dn, preset[7:0], exp_count[7:0], exp_cout_n}
    localparam logic [20:0] VEC [0:NV-1] = '{
        {4'b1001, 8'h0E, 8'h0E, 1'b1},  // R5 load
        {4'b0001, 8'h00, 8'h0F, 1'b1},  // R1
        {4'b0001, 8'h00, 8'h10, 1'b1},  // R10 carry into upper
        {4'b0001, 8'h00, 8'h11, 1'b1},  // R1
        {4'b0000, 8'h00, 8'h10, 1'b1},  // R2
        {4'b0000, 8'h00, 8'h0F, 1'b1},  // R10 borrow from upper
        {4'b0010, 8'h00, 8'h0F, 1'b1},  // R3 hold
        {4'b1000, 8'h01, 8'h01, 1'b1},  // R5
        {4'b0000, 8'h00, 8'h00, 1'b0},  // R9 terminal down
        {4'b0000, 8'h00, 8'hFF, 1'b1},  // R7 down wrap
        {4'b0010, 8'h00, 8'hFF, 1'b1},  // R3
        {4'b0001, 8'h00, 8'h00, 1'b1},  // R7 up wrap
        {4'b1001, 8'hFF, 8'hFF, 1'b0},  // R8 terminal up
        {4'b0011, 8'h00, 8'hFF, 1'b1},  // R8 cin high blocks carry
        {4'b1101, 8'h55, 8'h00, 1'b1}   // R6 clear beats load
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R11 reset count", 32'(count), 32'h00);
        chk("R11 reset cout", 32'(cout_n), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {load, clr, cin_n, up_dn, preset} = VEC[i][20:9];
            @(posedge clk);
            #1;
            chk($sformatf("R1-table row %0d count", i), 32'(count), 32'(VEC[i][8:1]));
            chk($sformatf("R8/R9 table row %0d cout", i), 32'(cout_n), 32'(VEC[i][0]));
        end

        // R1: resume counting after clear/load
        @(negedge clk);
        {load, clr, cin_n, up_dn} = 4'b0001;
        @(posedge clk); #1;
        chk("R1 resume", 32'(count), 32'h01);

        // R5: load shows immediately, blocks counting, resumes after release
        preset = 8'hA5; load = 1'b1; #1;
        chk("R5 immediate load", 32'(count), 32'hA5);
        @(posedge clk); #1;
        chk("R5 load blocks edge", 32'(count), 32'hA5);
        @(negedge clk); load = 1'b0;
        @(posedge clk); #1;
        chk("R5 count from loaded", 32'(count), 32'hA6);

        // R4: clear shows immediately and holds across an edge
        clr = 1'b1; #1;
        chk("R4 immediate clear", 32'(count), 32'h00);
        @(posedge clk); #1;
        chk("R4 clear blocks edge", 32'(count), 32'h00);
        @(negedge clk); clr = 1'b0;
        @(posedge clk); #1;
        chk("R4 count after clear", 32'(count), 32'h01);

        // R9: carry-out follows carry-in within a cycle at zero, down
        @(negedge clk);
        preset = 8'h00; load = 1'b1; up_dn = 1'b0; cin_n = 1'b1;
        @(posedge clk);
        @(negedge clk); load = 1'b0; #1;
        chk("R9 cin high no carry", 32'(cout_n), 32'h1);
        cin_n = 1'b0; #1;
        chk("R9 combinational carry", 32'(cout_n), 32'h0);
        @(posedge clk); #1;
        chk("R7 down wrap across stages", 32'(count), 32'hFF);

        // R11: synchronous reset wins over counting
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R11 reset is synchronous", 32'(count), 32'hFF);
        @(posedge clk); #1;
        chk("R11 reset on edge", 32'(count), 32'h00);
        @(negedge clk); rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule